// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block holds a small array of 64-bit words and applies one atomic operation to one of them per accepted request. A request names a word, an opcode, one or two operands, a width (full 64-bit word or its low 32-bit half), a signedness for the ordering operations, and whether the caller wants the prior value back. In a single clock the unit reads the addressed word, computes the replacement, writes it back and, when asked, schedules a response holding the word as it was before the update.

The operations cover bitwise combine (and, or, xor), arithmetic (add, subtract, increment by one, decrement by one), exchange, compare-and-swap, and ordering replacement (maximum, minimum). Because the whole read, modify and write happens in the cycle of acceptance, a stream of requests to the same word with no gaps sees each earlier result. Two saturating counters track how many compare-and-swap operations ran and how many of them found a mismatch. An unknown opcode is refused with a one-cycle error pulse.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `req_ready` is high whenever reset is released, a request is taken in every cycle where `req_valid` is high, and a request in the next cycle to the same word sees the value written by the previous one.
- R2: Opcode encodings are and=0, or=1, xor=2, cas=3, exchange=4, add=5, sub=6, inc=7, dec=8, max=9, min=10; and, or, xor, add and sub store the old word combined with `req_opa`, add and sub wrapping modulo the selected width, and exchange stores `req_opa` unchanged.
- R3: Increment stores the old word plus one and decrement stores the old word minus one, both wrapping modulo the selected width and ignoring both operands.
- R4: Compare-and-swap stores `req_opb` only when the old word equals `req_opa` over the selected width, and otherwise leaves the word unchanged.
- R5: `cas_tries` counts every accepted compare-and-swap and `cas_fails` counts those whose comparison failed; both start at zero and saturate at their all-ones value, updating one clock after acceptance.
- R6: Max replaces the word only when `req_opa` is strictly greater and min only when it is strictly smaller, comparing as two's-complement numbers when `req_signed` is 1 and as unsigned numbers when it is 0.
- R7: With `req_wide` at 0 the operation uses bits 31:0 only, bits 63:32 of the stored word are kept, and the returned value has bits 63:32 at zero; with `req_wide` at 1 all 64 bits take part.
- R8: With `req_ret` at 1, `rsp_valid` is high for the single cycle after acceptance and `rsp_data` then holds the word as it was before the update (for every operation, including a failed compare-and-swap); with `req_ret` at 0 no response appears.
- R9: An opcode of 11 to 15 leaves the word and both counters unchanged, produces no response, and raises `err_flag` for the single cycle after acceptance.
- R10: After reset every word reads zero and `rsp_valid`, `err_flag`, `cas_tries` and `cas_fails` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Word index |
| req_wide | input | 1 | 1 = 64-bit, 0 = low 32-bit |
| req_signed | input | 1 | Signed ordering for max and min |
| req_ret | input | 1 | Return the prior value |
| req_opa | input | 64 | First operand (compare value for cas) |
| req_opb | input | 64 | Second operand (swap value for cas) |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Prior value of the word |
| err_flag | output | 1 | Unknown opcode was refused |
| cas_tries | output | CNT_W | Compare-and-swap count |
| cas_fails | output | CNT_W | Failed compare-and-swap count |

## Verification
The assertions assume that request inputs are stable and known around each rising edge and that reset is held for at least one edge before the first request. The bench drives every request field on the falling edge and holds it until the next falling edge, so each field is settled half a cycle before the edge that accepts it, and it issues no request until reset has been released. Unused operand fields are still driven with defined values so that the ignored-operand checks see real numbers.

// File: rtl/atom_pkg.sv
package atom_pkg;

  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int KEY_W  = WORD_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_CAS  = 4'd3,
    OP_XCHG = 4'd4,
    OP_ADD  = 4'd5,
    OP_SUB  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_MAX  = 4'd9,
    OP_MIN  = 4'd10
  } atom_op_e;

  localparam logic [3:0] LAST_OP = 4'd10;

  function automatic logic op_known(logic [3:0] code);
    return code <= LAST_OP;
  endfunction

  // Extend the active part of a word to a common signed ordering key.
  function automatic logic [KEY_W-1:0] order_key(word_t v, logic wide, logic sgn);
    if (wide)
      return {sgn & v[WORD_W-1], v};
    else
      return {{(HALF_W+1){sgn & v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic key_greater(word_t a, word_t b, logic wide, logic sgn);
    logic [KEY_W-1:0] ka, kb;
    ka = order_key(a, wide, sgn);
    kb = order_key(b, wide, sgn);
    return $signed(ka) > $signed(kb);
  endfunction

  function automatic logic same_value(word_t a, word_t b, logic wide);
    if (wide) return a == b;
    else      return a[HALF_W-1:0] == b[HALF_W-1:0];
  endfunction

  // Fold a full-width result into the stored word for the chosen width.
  function automatic word_t fold_result(word_t old, word_t res, logic wide);
    if (wide) return res;
    else      return {old[WORD_W-1:HALF_W], res[HALF_W-1:0]};
  endfunction

  function automatic word_t visible_part(word_t v, logic wide);
    if (wide) return v;
    else      return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

endpackage

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
(
  input  logic [3:0] op,
  input  word_t      old_word,
  input  word_t      opa,
  input  word_t      opb,
  input  logic       wide,
  input  logic       sgn,
  output word_t      new_word,
  output logic       cas_match
);

  word_t raw;

  always_comb begin
    cas_match = same_value(old_word, opa, wide);
    raw       = old_word;
    unique case (op)
      OP_AND:  raw = old_word & opa;
      OP_OR:   raw = old_word | opa;
      OP_XOR:  raw = old_word ^ opa;
      OP_CAS:  raw = cas_match ? opb : old_word;
      OP_XCHG: raw = opa;
      OP_ADD:  raw = old_word + opa;
      OP_SUB:  raw = old_word - opa;
      OP_INC:  raw = old_word + word_t'(1);
      OP_DEC:  raw = old_word - word_t'(1);
      OP_MAX:  raw = key_greater(opa, old_word, wide, sgn) ? opa : old_word;
      OP_MIN:  raw = key_greater(old_word, opa, wide, sgn) ? opa : old_word;
      default: raw = old_word;
    endcase
    new_word = fold_result(old_word, raw, wide);
  end

endmodule

// File: rtl/atom_store.sv
module atom_store
  import atom_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data
);

  localparam int DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];

  assign rd_data = mem[rd_addr];

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[gi] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(gi))
          mem[gi] <= wr_data;
      end
    end
  endgenerate

  // R1: a write is visible at the same word on the following cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/atom_cas_count.sv
module atom_cas_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_evt,
  input  logic             cas_miss,
  output logic [CNT_W-1:0] tries,
  output logic [CNT_W-1:0] fails
);

  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries <= '0;
      fails <= '0;
    end else begin
      if (cas_evt && tries != TOP)
        tries <= tries + 1'b1;
      if (cas_evt && cas_miss && fails != TOP)
        fails <= fails + 1'b1;
    end
  end

  // R5: failures never exceed attempts
  p_fail_le_try_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fails <= tries);

  // R5: every attempt moves the count unless it is saturated
  p_try_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cas_evt |=> (tries != $past(tries)) || ($past(tries) == TOP));

  // R5: no attempt, no change
  p_try_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_evt |=> $stable(tries) && $stable(fails));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wide,
  input  logic              req_signed,
  input  logic              req_ret,
  input  logic [63:0]       req_opa,
  input  logic [63:0]       req_opb,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              err_flag,
  output logic [CNT_W-1:0]  cas_tries,
  output logic [CNT_W-1:0]  cas_fails
);

  // Named internal events
  logic  accept, bad_op, wr_en, cas_evt, cas_miss, cas_match;
  word_t old_word, new_word;

  assign req_ready = rst_n;
  assign accept    = req_valid && req_ready;
  assign bad_op    = !op_known(req_op);
  assign wr_en     = accept && !bad_op;
  assign cas_evt   = wr_en && (req_op == OP_CAS);
  assign cas_miss  = cas_evt && !cas_match;

  atom_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (req_addr),
    .rd_data (old_word),
    .wr_en   (wr_en),
    .wr_addr (req_addr),
    .wr_data (new_word)
  );

  atom_alu u_alu (
    .op        (req_op),
    .old_word  (old_word),
    .opa       (req_opa),
    .opb       (req_opb),
    .wide      (req_wide),
    .sgn       (req_signed),
    .new_word  (new_word),
    .cas_match (cas_match)
  );

  atom_cas_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_evt  (cas_evt),
    .cas_miss (cas_miss),
    .tries    (cas_tries),
    .fails    (cas_fails)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= wr_en && req_ret;
      err_flag  <= accept && bad_op;
      if (wr_en && req_ret)
        rsp_data <= visible_part(old_word, req_wide);
    end
  end

  // R8: a response only follows an accepted returning request
  p_rsp_from_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ret));

  // R9: a refused request gives no response
  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !rsp_valid);

  // R3: a full-width increment advances the word by one
  p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_op == OP_INC && req_wide) |-> new_word == old_word + 64'd1);

  // R7: narrow requests keep the upper half of the stored word
  p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !req_wide) |-> new_word[63:32] == old_word[63:32]);

  // R4: a failed compare leaves the word as it was
  p_cas_miss_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cas_miss |-> new_word == old_word);

endmodule

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;

  localparam int ADDR_W = 3;
  localparam int CNT_W  = 16;
  localparam logic [63:0] ONES = '1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_wide = 1'b1;
  logic              req_signed = 1'b0;
  logic              req_ret = 1'b0;
  logic [63:0]       req_opa = '0;
  logic [63:0]       req_opb = '0;
  logic              rsp_valid;
  logic [63:0]       rsp_data;
  logic              err_flag;
  logic [CNT_W-1:0]  cas_tries;
  logic [CNT_W-1:0]  cas_fails;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  logic        got_rsp, got_err;
  logic [63:0] got_data;

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wide(req_wide),
    .req_signed(req_signed), .req_ret(req_ret), .req_opa(req_opa),
    .req_opb(req_opb), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .err_flag(err_flag), .cas_tries(cas_tries), .cas_fails(cas_fails)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One request, one cycle; results sampled at the following falling edge.
  task automatic issue(logic [3:0] op, int addr, logic wide, logic sgn,
                       logic ret, logic [63:0] a, logic [63:0] b);
    req_valid  = 1'b1;
    req_op     = op;
    req_addr   = ADDR_W'(addr);
    req_wide   = wide;
    req_signed = sgn;
    req_ret    = ret;
    req_opa    = a;
    req_opb    = b;
    @(posedge clk);
    @(negedge clk);
    got_rsp  = rsp_valid;
    got_data = rsp_data;
    got_err  = err_flag;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic peek(int addr, output logic [63:0] v);
    issue(4'd1, addr, 1'b1, 1'b0, 1'b1, 64'd0, 64'd0);
    v = got_data;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R10 err_flag", {63'd0, err_flag}, 64'd0);
    chk("R10 cas_tries", 64'(cas_tries), 64'd0);
    chk("R10 cas_fails", 64'(cas_fails), 64'd0);
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    peek(5, v);
    chk("R10 word zero", v, 64'd0);
    idle();
  endtask

  task automatic t_logic();
    logic [63:0] v;
    issue(4'd4, 1, 1, 0, 1, 64'hF0F0, 0);
    chk("R8 xchg old", got_data, 64'd0);
    issue(4'd0, 1, 1, 0, 1, 64'h0FF0, 0);
    chk("R2 and old", got_data, 64'hF0F0);
    issue(4'd2, 1, 1, 0, 1, 64'h00FF, 0);
    chk("R2 xor old", got_data, 64'h00F0);
    issue(4'd1, 1, 1, 0, 1, 64'h0100, 0);
    chk("R2 or old", got_data, 64'h000F);
    peek(1, v);
    chk("R2 or result", v, 64'h010F);
    issue(4'd4, 1, 1, 0, 0, ONES, 0);
    issue(4'd5, 1, 1, 0, 0, 64'd2, 0);
    peek(1, v);
    chk("R2 add wraps", v, 64'd1);
    issue(4'd6, 1, 1, 0, 0, 64'd3, 0);
    peek(1, v);
    chk("R2 sub wraps", v, ONES - 64'd1);
    idle();
  endtask

  task automatic t_width();
    logic [63:0] v;
    issue(4'd4, 2, 1, 0, 0, 64'hAAAA_BBBB_0000_0005, 0);
    issue(4'd6, 2, 0, 0, 1, 64'd6, 0);
    chk("R7 narrow ret zero-extended", got_data, 64'h5);
    peek(2, v);
    chk("R7 narrow sub keeps upper", v, 64'hAAAA_BBBB_FFFF_FFFF);
    issue(4'd7, 2, 0, 0, 0, 64'h1234, 64'h5678);
    peek(2, v);
    chk("R3 narrow inc wraps", v, 64'hAAAA_BBBB_0000_0000);
    issue(4'd8, 2, 0, 0, 0, 64'h99, 64'h77);
    peek(2, v);
    chk("R3 narrow dec wraps", v, 64'hAAAA_BBBB_FFFF_FFFF);
    issue(4'd4, 2, 1, 0, 0, 0, 0);
    issue(4'd8, 2, 1, 0, 0, 64'd5, 64'd9);
    peek(2, v);
    chk("R3 wide dec ignores operands", v, ONES);
    issue(4'd7, 2, 1, 0, 0, 64'd5, 64'd9);
    peek(2, v);
    chk("R3 wide inc ignores operands", v, 64'd0);
    issue(4'd4, 2, 0, 0, 0, 64'hFFFF_FFFF_1234_5678, 0);
    peek(2, v);
    chk("R7 narrow xchg", v, 64'h0000_0000_1234_5678);
    idle();
  endtask

  task automatic t_cas();
    logic [63:0] v;
    issue(4'd4, 4, 1, 0, 0, 64'd10, 0);
    issue(4'd3, 4, 1, 0, 1, 64'd10, 64'd20);
    chk("R4 cas hit old", got_data, 64'd10);
    issue(4'd3, 4, 1, 0, 1, 64'd10, 64'd30);
    chk("R8 cas miss returns old", got_data, 64'd20);
    chk("R5 tries", 64'(cas_tries), 64'd2);
    chk("R5 fails", 64'(cas_fails), 64'd1);
    peek(4, v);
    chk("R4 cas miss keeps", v, 64'd20);
    issue(4'd4, 4, 1, 0, 0, 64'h7_0000_0014, 0);
    issue(4'd3, 4, 0, 0, 0, 64'h14, 64'h9_0000_0033);
    peek(4, v);
    chk("R4 narrow cas hit", v, 64'h7_0000_0033);
    idle();
  endtask

  task automatic t_order();
    logic [63:0] v;
    issue(4'd4, 3, 1, 0, 0, 64'd5, 0);
    issue(4'd9, 3, 1, 0, 0, 64'd3, 0);
    issue(4'd9, 3, 1, 1, 0, ONES, 0);
    peek(3, v);
    chk("R6 max keeps larger", v, 64'd5);
    issue(4'd9, 3, 1, 0, 0, ONES, 0);
    peek(3, v);
    chk("R6 unsigned max", v, ONES);
    issue(4'd10, 3, 1, 1, 0, 64'd2, 0);
    peek(3, v);
    chk("R6 signed min keeps -1", v, ONES);
    issue(4'd10, 3, 1, 0, 0, 64'd2, 0);
    peek(3, v);
    chk("R6 unsigned min", v, 64'd2);
    issue(4'd4, 3, 1, 0, 0, 64'h7_0000_0001, 0);
    issue(4'd9, 3, 0, 1, 0, 64'h8000_0000, 0);
    peek(3, v);
    chk("R6 narrow signed max", v, 64'h7_0000_0001);
    issue(4'd9, 3, 0, 0, 0, 64'h8000_0000, 0);
    peek(3, v);
    chk("R6 narrow unsigned max", v, 64'h7_8000_0000);
    issue(4'd10, 3, 0, 1, 0, 64'd1, 0);
    peek(3, v);
    chk("R6 narrow signed min", v, 64'h7_8000_0000);
    issue(4'd10, 3, 0, 0, 0, 64'd1, 0);
    peek(3, v);
    chk("R6 narrow unsigned min", v, 64'h7_0000_0001);
    issue(4'd10, 3, 0, 0, 0, 64'd1, 0);
    peek(3, v);
    chk("R6 min strict on equal", v, 64'h7_0000_0001);
    idle();
  endtask

  task automatic t_noret_and_bad();
    logic [63:0] v;
    issue(4'd1, 3, 1, 0, 0, 64'h10, 0);
    chk("R8 no-ret silent", {63'd0, got_rsp}, 64'd0);
    peek(3, v);
    chk("R8 no-ret still writes", v, 64'h7_0000_0011);
    issue(4'd13, 3, 1, 0, 1, 64'd0, 64'd0);
    chk("R9 err raised", {63'd0, got_err}, 64'd1);
    chk("R9 no rsp", {63'd0, got_rsp}, 64'd0);
    issue(4'd11, 3, 1, 0, 1, 64'd0, 64'd0);
    chk("R9 op 11 err", {63'd0, got_err}, 64'd1);
    chk("R9 counters tries", 64'(cas_tries), 64'd3);
    chk("R9 counters fails", 64'(cas_fails), 64'd1);
    peek(3, v);
    chk("R9 word untouched", v, 64'h7_0000_0011);
    chk("R9 err one cycle", {63'd0, got_err}, 64'd0);
    idle();
    chk("R8 rsp one cycle", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_back2back();
    issue(4'd4, 6, 1, 0, 0, 64'd0, 0);
    for (int k = 0; k < 3; k++) begin
      issue(4'd7, 6, 1, 0, 1, 64'd0, 0);
      chk("R1 back-to-back inc", got_data, 64'(k));
      chk("R8 rsp valid", {63'd0, got_rsp}, 64'd1);
    end
    idle();
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 65540; k++)
      issue(4'd3, 7, 1, 0, 0, 64'd1, 64'd2);
    idle();
    chk("R5 tries saturate", 64'(cas_tries), 64'hFFFF);
    chk("R5 fails saturate", 64'(cas_fails), 64'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_logic();
    t_width();
    t_cas();
    t_order();
    t_noret_and_bad();
    t_back2back();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule